// File: doc/BRIEF.md
# Posted-Write Queue with Read Forwarding

This block sits between a cache and the next level of memory. It takes single-word stores from a write-through cache and dirty-block evictions from a write-back cache. It holds them in a small queue and sends them downstream in the background. The cache can therefore continue as soon as a store is queued, and a refill read for a miss can be issued before the eviction that preceded it has reached memory.

A read miss can present its address on a lookup port. The block searches every pending entry. One cycle later it returns the data of the newest matching entry, so the read need not wait for the queue to drain. A store to an address that is already queued behind the oldest entry overwrites that entry in place and uses no new slot. The oldest entry is never modified, because it is on offer downstream. The upstream side is told to hold a store only when no slot can be found for it.

Top module: `wrbuf_fwd`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_valid`, `rd_hit` and `wr_stall` are 0 and the queue is empty.
- R2: A store (`wr_valid`=1) is accepted in the same cycle, with `wr_stall`=0, whenever fewer than DEPTH (default 4) entries are pending.
- R3: Pending entries go out on `mem_addr`/`mem_data` in arrival order. `mem_valid` is 1 exactly when at least one entry is pending, and an entry leaves at a rising edge where `mem_valid` and `mem_ready` are both 1.
- R4: `wr_stall` is 1 exactly when `wr_valid` is 1, all DEPTH entries are pending, no entry leaves in that cycle and the address matches no pending entry other than the oldest. A stalled store changes nothing in the queue.
- R5: On a full queue, a store that arrives in the same cycle as a downstream transfer is accepted without a stall.
- R6: A store whose address equals a pending entry other than the oldest replaces that entry's data and takes no new slot. This applies even when the queue is full.
- R7: A store whose address matches only the oldest entry is appended as a new entry. The oldest entry still goes downstream with its original data.
- R8: A lookup with `rd_valid`=1 gives, in the next cycle, `rd_hit`=1 and `rd_data` equal to the data of the most recently queued matching entry. If no entry matches or `rd_valid`=0, it gives `rd_hit`=0 and `rd_data`=0.
- R9: A lookup sees the entries pending before the edge that ends its cycle. An entry that leaves in that cycle still hits, and a store made in that cycle is not seen.
- R10: While `mem_valid`=1 and `mem_ready`=0, `mem_addr` and `mem_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request from the cache |
| wr_addr | input | AW | Word address of the store |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Store not taken this cycle; hold it |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | AW | Address looked up |
| rd_hit | output | 1 | Registered: lookup found a pending entry |
| rd_data | output | DW | Registered: forwarded data, 0 on a miss |
| mem_valid | output | 1 | An entry is on offer downstream |
| mem_ready | input | 1 | Downstream takes the offered entry |
| mem_addr | output | AW | Address of the oldest entry |
| mem_data | output | DW | Data of the oldest entry |

## Verification
The bench sends stores to a full queue with and without a simultaneous drain. If the stall ignored the drain, R5 would fail with a lost cycle. If the stall ignored the full condition, R4 would fail and an entry would be overwritten. The bench also sends a second store to an address that sits in the oldest slot and to one that sits deeper in the queue. A design that merged into the oldest slot would change data already on offer downstream. A design that never merged would use an extra slot and stall too early. Lookups are placed in the same cycle as a drain of the matching entry and as a store to the looked-up address. A design that sampled the updated contents would miss the leaving entry or forward data that was not yet queued. With duplicate addresses present, a priority chosen by slot number instead of age would return stale data.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
  // What happens to an incoming store in the current cycle.
  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_APPEND = 2'd1,
    WR_MERGE  = 2'd2,
    WR_HOLD   = 2'd3
  } wr_act_e;
endpackage

// File: rtl/wbuf_match.sv
// Parallel address compare over all slots. Returns the youngest live match,
// age measured from the head pointer.
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0]         live,
  input  logic [PW-1:0]            head,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [PW-1:0]            slot
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = live[g] && (slot_addr[g] == key);
  end

  // Walk from oldest to youngest; the last match seen wins.
  always_comb begin
    hit  = 1'b0;
    slot = head;
    for (int k = 0; k < DEPTH; k++) begin
      if (eq[head + PW'(k)]) begin
        hit  = 1'b1;
        slot = head + PW'(k);
      end
    end
  end
endmodule

// File: rtl/wbuf_store.sv
// Circular entry storage. The data arrays have no reset; only the pointers
// and the occupancy count are cleared.
module wbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     merge,
  input  logic [PW-1:0]            merge_slot,
  input  logic [DW-1:0]            merge_data,
  input  logic                     pop,
  output logic [PW-1:0]            head,
  output logic [CW-1:0]            count,
  output logic [DEPTH-1:0]         live,
  output logic [DEPTH-1:0][AW-1:0] slot_addr,
  output logic [DEPTH-1:0][DW-1:0] slot_data
);
  logic [AW-1:0] a_q [DEPTH];
  logic [DW-1:0] d_q [DEPTH];
  logic [PW-1:0] tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (pop)  head <= head + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      a_q[tail] <= push_addr;
      d_q[tail] <= push_data;
    end
    if (merge) d_q[merge_slot] <= merge_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PW-1:0] age;
    assign age          = PW'(g) - head;
    assign live[g]      = CW'(age) < count;
    assign slot_addr[g] = a_q[g];
    assign slot_data[g] = d_q[g];
  end
endmodule

// File: rtl/wrbuf_fwd.sv
module wrbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stall,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  import wrbuf_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]            head;
  logic [CW-1:0]            cnt;
  logic [DEPTH-1:0]         live;
  logic [DEPTH-1:0]         live_tail;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic                     full;
  logic                     pop;
  logic                     push;
  logic                     merge;
  logic                     mg_hit;
  logic [PW-1:0]            mg_slot;
  logic                     lk_hit;
  logic [PW-1:0]            lk_slot;
  wr_act_e                  act;

  assign full      = (cnt == CW'(DEPTH));
  assign mem_valid = (cnt != '0);
  assign pop       = mem_valid && mem_ready;
  assign mem_addr  = slot_addr[head];
  assign mem_data  = slot_data[head];

  // The head entry is on offer downstream and is excluded from merging.
  assign live_tail = live & ~(DEPTH'(1) << head);

  wbuf_match #(.DEPTH(DEPTH), .AW(AW)) i_merge_cmp (
    .slot_addr (slot_addr),
    .live      (live_tail),
    .head      (head),
    .key       (wr_addr),
    .hit       (mg_hit),
    .slot      (mg_slot)
  );

  wbuf_match #(.DEPTH(DEPTH), .AW(AW)) i_lookup_cmp (
    .slot_addr (slot_addr),
    .live      (live),
    .head      (head),
    .key       (rd_addr),
    .hit       (lk_hit),
    .slot      (lk_slot)
  );

  always_comb begin
    if (!wr_valid)          act = WR_IDLE;
    else if (mg_hit)        act = WR_MERGE;
    else if (full && !pop)  act = WR_HOLD;
    else                    act = WR_APPEND;
  end

  assign wr_stall = (act == WR_HOLD);
  assign push     = (act == WR_APPEND);
  assign merge    = (act == WR_MERGE);

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_addr  (wr_addr),
    .push_data  (wr_data),
    .merge      (merge),
    .merge_slot (mg_slot),
    .merge_data (wr_data),
    .pop        (pop),
    .head       (head),
    .count      (cnt),
    .live       (live),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data)
  );

  // Lookup result is registered; it reflects the entries before this edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_hit  <= rd_valid && lk_hit;
      rd_data <= (rd_valid && lk_hit) ? slot_data[lk_slot] : '0;
    end
  end
endmodule

// File: rtl/wrbuf_fwd_chk.sv
module wrbuf_fwd_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stall,
  input logic          rd_valid,
  input logic          rd_hit,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [CW-1:0] cnt,
  input logic          push
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!mem_valid && !rd_hit && !wr_stall));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stall |=> (cnt == $past(cnt)));

  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R8
  idle_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rd_hit);

  // R3
  drain_count_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !push) |=> (cnt == $past(cnt) - CW'(1)));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

bind wrbuf_fwd wrbuf_fwd_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stall  (wr_stall),
  .rd_valid  (rd_valid),
  .rd_hit    (rd_hit),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .cnt       (cnt),
  .push      (push)
);

// File: tb/test_wrbuf_fwd.sv
`timescale 1ns/1ps
module test_wrbuf_fwd;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_stall;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_hit;
  logic [31:0] rd_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;

  always #4 clk = ~clk;

  wrbuf_fwd i_wrbuf_fwd (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference queue, index 0 is the oldest entry.
  logic [31:0] ma [N];
  logic [31:0] md [N];
  int          mc = 0;
  bit          exp_hit = 0;
  logic [31:0] exp_rdd = '0;
  bit          prev_hold = 0;
  logic [31:0] prev_a = '0;
  logic [31:0] prev_d = '0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_stall(bit wv, logic [31:0] wa, bit rdy);
    bit mrg = 0;
    for (int k = 1; k < mc; k++) if (ma[k] == wa) mrg = 1;
    return wv && (mc == N) && !(rdy && mc != 0) && !mrg;
  endfunction

  // One cycle, called at a falling edge. Checks the outputs, drives inputs,
  // checks the stall, then advances the model to the next falling edge.
  task automatic cycle(bit wv, logic [31:0] wa, logic [31:0] wd, bit rv, logic [31:0] ra,
                       bit rdy, string tm, string ts, string tl);
    int mk;
    bit pop, stl, lh;
    logic [31:0] ld;
    chk(mem_valid == (mc != 0), tm, "mem_valid", 32'(mem_valid), 32'(mc != 0));
    if (mc != 0) begin
      chk(mem_addr == ma[0], tm, "mem_addr", mem_addr, ma[0]);
      chk(mem_data == md[0], tm, "mem_data", mem_data, md[0]);
    end
    chk(rd_hit == exp_hit, tl, "rd_hit", 32'(rd_hit), 32'(exp_hit));
    chk(rd_data == exp_rdd, tl, "rd_data", rd_data, exp_rdd);
    if (prev_hold) begin
      chk(mem_addr == prev_a, "R10", "held mem_addr", mem_addr, prev_a);
      chk(mem_data == prev_d, "R10", "held mem_data", mem_data, prev_d);
    end
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_valid = rv; rd_addr = ra; mem_ready = rdy;
    #1;
    stl = model_stall(wv, wa, rdy);
    chk(wr_stall == stl, ts, "wr_stall", 32'(wr_stall), 32'(stl));
    pop = rdy && (mc != 0);
    mk = -1;
    for (int k = 1; k < mc; k++) if (ma[k] == wa) mk = k;
    lh = 0; ld = '0;
    if (rv) for (int k = 0; k < mc; k++) if (ma[k] == ra) begin lh = 1; ld = md[k]; end
    prev_hold = (mc != 0) && !rdy;
    prev_a = ma[0]; prev_d = md[0];
    if (wv && mk >= 0) md[mk] = wd;
    if (pop) begin
      for (int k = 0; k < N - 1; k++) begin ma[k] = ma[k+1]; md[k] = md[k+1]; end
      mc--;
    end
    if (wv && !stl && mk < 0) begin ma[mc] = wa; md[mc] = wd; mc++; end
    exp_hit = lh; exp_rdd = ld;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: state after reset
    chk(mem_valid == 1'b0, "R1", "mem_valid", 32'(mem_valid), 0);
    chk(rd_hit == 1'b0, "R1", "rd_hit", 32'(rd_hit), 0);
    chk(wr_stall == 1'b0, "R1", "wr_stall", 32'(wr_stall), 0);
    @(negedge clk);
    chk(mem_valid == 1'b0, "R1", "mem_valid later", 32'(mem_valid), 0);

    // R2: fill without draining
    for (int i = 0; i < N; i++)
      cycle(1, 32'h100 + 32'(i*4), 32'hA0 + 32'(i), 0, '0, 0, "R3", "R2", "R8");
    // R4: full, no drain, new address -> stall, nothing changes
    cycle(1, 32'h200, 32'hBAD, 0, '0, 0, "R3", "R4", "R8");
    cycle(1, 32'h200, 32'hBAD, 1, 32'h104, 0, "R3", "R4", "R8");
    cycle(0, '0, '0, 1, 32'h200, 0, "R4", "R2", "R8");
    // R6: merge into a deeper entry while full
    cycle(1, 32'h108, 32'hC8, 0, '0, 0, "R6", "R6", "R6");
    cycle(0, '0, '0, 1, 32'h108, 0, "R6", "R2", "R6");
    // R5: full, write with simultaneous drain
    cycle(1, 32'h300, 32'hD0, 0, '0, 1, "R5", "R5", "R6");
    cycle(0, '0, '0, 0, '0, 1, "R3", "R2", "R8");
    // R7: write to the address held only by the oldest entry
    cycle(1, 32'h108, 32'hE8, 0, '0, 0, "R7", "R7", "R8");
    cycle(0, '0, '0, 1, 32'h108, 0, "R7", "R2", "R8");
    cycle(0, '0, '0, 0, '0, 1, "R7", "R2", "R7");
    // R9: lookup of the entry leaving this cycle, and of a same-cycle store
    cycle(0, '0, '0, 1, 32'h10C, 1, "R9", "R2", "R8");
    cycle(1, 32'h400, 32'h44, 1, 32'h400, 0, "R9", "R2", "R9");
    cycle(0, '0, '0, 1, 32'h400, 0, "R9", "R2", "R9");
    repeat (6) cycle(0, '0, '0, 0, '0, 1, "R3", "R2", "R9");

    // Constrained random traffic over a small address pool
    for (int n = 0; n < 4000; n++) begin
      bit wv  = ($urandom % 3) != 0;
      bit rv  = ($urandom % 2) != 0;
      bit rdy = ($urandom % 5) < 2;
      logic [31:0] wa = 32'h1000 + 32'(($urandom % 6) * 4);
      logic [31:0] ra = 32'h1000 + 32'(($urandom % 7) * 4);
      cycle(wv, wa, $urandom, rv, ra, rdy, "R3", "R4", "R8");
    end
    repeat (6) cycle(0, '0, '0, 0, '0, 1, "R3", "R2", "R8");
    finish_run();
  end
endmodule